// File: doc/BRIEF.md
# Dual-Channel Bus-Master IDE Interrupt and Status Registers

This block holds the byte-wide registers that software reaches for each channel of a two-channel bus-master IDE controller. Each channel has a command byte, a status byte and a drive timing byte. Both channels also see one shared mode byte, which carries an interrupt flag and a mask bit for each channel. The block merges the two channels into one level-sensitive PCI interrupt line.

Software uses a 4-bit byte address. Address bit 3 picks the channel, so the second channel's window sits 8 bytes above the first. Address bits 1:0 pick the register inside the window. Addresses with bit 2 set belong to the descriptor pointer, which is handled elsewhere. Those addresses read as zero here, and writes to them do nothing.

Each drive channel supplies an interrupt level, an error pulse and an engine-active level. The flag bits follow the interrupt levels. The status bits latch the events until software clears them.

Top module: `ide_irq_regs`

## Requirements
- R1: After reset, every register reads as zero, apart from status bit 0, which shows the live active input. The interrupt output is low after reset.
- R2: Address bit 3 selects the channel. Address bits 1:0 select the register: 0 is command, 1 is mode, 2 is status, 3 is timing. An address with bit 2 set reads as zero, and a write to it changes no register.
- R3: Each channel has its own 8-bit command register. A write stores the full byte, and a read returns that byte.
- R4: The shared mode register can be written through either channel window. A write changes only bit 4 (channel 0 mask) and bit 5 (channel 1 mask). Bits 7:6 and 1:0 always read as zero.
- R5: Mode bit 2 follows the channel 0 interrupt input, and mode bit 3 follows the channel 1 interrupt input. Each flag takes its input level on the next clock edge.
- R6: The interrupt output equals (flag0 AND NOT mask0) OR (flag1 AND NOT mask1). It is computed from the registered flags and masks, so it responds in the cycle after a change of interrupt input or a mode write. When an interrupt input change and a mode write fall in the same cycle, both take effect.
- R7: Status bits 6:5 take the written value on a status write. Status bits 7, 4 and 3 always read as zero.
- R8: Status bit 1 is set by a pulse on that channel's error input. Status bit 2 is set when that channel's interrupt input rises. Writing a 1 to either bit clears it, and writing a 0 leaves it unchanged. If a set event and a clearing write fall in the same cycle, the bit ends up set.
- R9: Status bit 0 shows that channel's active input at the time of the read. Writes do not change it.
- R10: Each channel has its own 8-bit timing register at offset 3. A write to one channel's copy leaves the other channel's copy unchanged.
- R11: Read data is valid in the same cycle as the read strobe. Read data is zero while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 4 | Byte address: bit 3 is the channel, bit 2 is the out-of-range window, bits 1:0 are the register |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational |
| chan_irq | input | 2 | Interrupt level from each drive channel |
| chan_active | input | 2 | Engine-active level from each channel, shown as status bit 0 |
| chan_err | input | 2 | Error pulse from each channel, sets status bit 1 |
| irq_out | output | 1 | Merged level-sensitive PCI interrupt |

## Verification
Two kinds of same-cycle collision are tested.

The first is a write to a mode mask that lands in the same cycle as a rising interrupt input. The bench drives both in the same clock, then checks two things: that the flag is set while the mask stays in force, and that the output stays low.

The second is a write-1-to-clear of status bit 2 that meets a new rising edge on the interrupt input. The bench reads the status back afterwards and expects the set event to have won.

// File: rtl/ide_irq_regs.sv
module ide_irq_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] io_rdata,
  input  logic [1:0]    chan_irq,
  input  logic [1:0]    chan_active,
  input  logic [1:0]    chan_err,
  output logic          irq_out
);
  localparam logic [1:0] OFF_CMD = 2'd0;
  localparam logic [1:0] OFF_MODE = 2'd1;
  localparam logic [1:0] OFF_STAT = 2'd2;
  localparam logic [1:0] OFF_TIME = 2'd3;

  logic [1:0][DW-1:0] cmd_q, time_q;
  logic [1:0][1:0]    ctl_q;
  logic [1:0]         err_q, evt_q, flag_q, mask_q;

  logic       ch, hit;
  logic [1:0] off;
  assign ch  = io_addr[3];
  assign hit = ~io_addr[2];
  assign off = io_addr[1:0];

  logic wr_cmd, wr_mode, wr_stat, wr_time;
  assign wr_cmd  = io_wr & hit & (off == OFF_CMD);
  assign wr_mode = io_wr & hit & (off == OFF_MODE);
  assign wr_stat = io_wr & hit & (off == OFF_STAT);
  assign wr_time = io_wr & hit & (off == OFF_TIME);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      time_q <= '0;
      ctl_q  <= '0;
      err_q  <= '0;
      evt_q  <= '0;
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      flag_q <= chan_irq;
      if (wr_mode) mask_q <= io_wdata[5:4];
      for (int c = 0; c < 2; c++) begin
        logic sel;
        sel = (ch == c[0]);
        if (wr_cmd && sel)  cmd_q[c]  <= io_wdata;
        if (wr_time && sel) time_q[c] <= io_wdata;
        if (wr_stat && sel) ctl_q[c]  <= io_wdata[6:5];
        err_q[c] <= chan_err[c] | (err_q[c] & ~(wr_stat & sel & io_wdata[1]));
        evt_q[c] <= (chan_irq[c] & ~flag_q[c]) |
                    (evt_q[c] & ~(wr_stat & sel & io_wdata[2]));
      end
    end
  end

  assign irq_out = (flag_q[0] & ~mask_q[0]) | (flag_q[1] & ~mask_q[1]);

  logic [DW-1:0] mode_byte, stat_byte;
  assign mode_byte = DW'({2'b00, mask_q, flag_q, 2'b00});
  assign stat_byte = DW'({1'b0, ctl_q[ch], 2'b00, evt_q[ch], err_q[ch], chan_active[ch]});

  always_comb begin
    io_rdata = '0;
    if (io_rd && hit) begin
      unique case (off)
        OFF_CMD:  io_rdata = cmd_q[ch];
        OFF_MODE: io_rdata = mode_byte;
        OFF_STAT: io_rdata = stat_byte;
        default:  io_rdata = time_q[ch];
      endcase
    end
  end
endmodule

module ide_irq_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] io_addr,
  input logic       io_wr,
  input logic       io_rd,
  input logic [7:0] io_rdata,
  input logic [1:0] chan_irq,
  input logic [1:0] chan_active,
  input logic [1:0] mask_q,
  input logic       irq_out
);
  logic mode_wr;
  assign mode_wr = io_wr && !io_addr[2] && io_addr[1:0] == 2'd1;

  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> io_rdata == 8'h00);
  assert_hole_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd && io_addr[2] |-> io_rdata == 8'h00);
  assert_active_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd && io_addr[2:0] == 3'd2 |-> io_rdata[0] == chan_active[io_addr[3]]);
  assert_stat_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd && io_addr[2:0] == 3'd2 |-> io_rdata[7] == 1'b0 && io_rdata[4:3] == 2'b00);
  assert_mode_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd && io_addr[2:0] == 3'd1 |-> io_rdata[7:6] == 2'b00 && io_rdata[1:0] == 2'b00);
  assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chan_irq == 2'b00 |=> !irq_out);
  assert_raise_ch0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr && chan_irq[0] && !mask_q[0] |=> irq_out);
  assert_raise_ch1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr && chan_irq[1] && !mask_q[1] |=> irq_out);
endmodule

bind ide_irq_regs ide_irq_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
  .io_rdata(io_rdata), .chan_irq(chan_irq), .chan_active(chan_active),
  .mask_q(mask_q), .irq_out(irq_out)
);

// File: tb/ide_irq_regs_test.sv
module ide_irq_regs_test;
  logic clk = 0, rst_n = 0, io_wr = 0, io_rd = 0, irq_out;
  logic [3:0] io_addr = '0;
  logic [7:0] io_wdata = '0, io_rdata;
  logic [1:0] chan_irq = '0, chan_active = '0, chan_err = '0;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  ide_irq_regs uut (.*);

  task automatic note(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && io_rd) begin
      if (exp_q.size() == 0) note(0, "scoreboard underflow", io_rdata, 8'h00);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        note(io_rdata === e, t, io_rdata, e);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1 io_addr = a; io_wdata = d; io_wr = 1;
    @(posedge clk); #1 io_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #1 io_addr = a; io_rd = 1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1 io_rd = 0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    note(irq_out === e, tag, {7'd0, irq_out}, {7'd0, e});
  endtask

  task automatic set_irq(input logic [1:0] v);
    @(posedge clk); #1 chan_irq = v;
    @(posedge clk); #1;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    note(0, "watchdog", 8'h00, 8'h01);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk_irq(0, "R1 irq after reset");
    rd(4'h0, 8'h00, "R1 cmd0"); rd(4'h1, 8'h00, "R1 mode");
    rd(4'h2, 8'h00, "R1 stat0"); rd(4'hB, 8'h00, "R1 time1");
    // R3 command per channel
    wr(4'h0, 8'hA5); wr(4'h8, 8'h3C);
    rd(4'h0, 8'hA5, "R3 cmd0"); rd(4'h8, 8'h3C, "R3 cmd1");
    // R10 timing per channel
    wr(4'h3, 8'h11); wr(4'hB, 8'h22);
    rd(4'h3, 8'h11, "R10 time0"); rd(4'hB, 8'h22, "R10 time1");
    // R2 hole ignored
    wr(4'h4, 8'hFF);
    rd(4'h0, 8'hA5, "R2 cmd0 kept"); rd(4'h4, 8'h00, "R2 hole read");
    rd(4'h7, 8'h00, "R2 hole read top"); rd(4'h3, 8'h11, "R2 time0 kept");
    // R4 mode masking through both windows
    wr(4'h1, 8'hFF);
    rd(4'h1, 8'h30, "R4 mode via ch0"); rd(4'h9, 8'h30, "R4 mode via ch1");
    wr(4'h9, 8'h10);
    rd(4'h1, 8'h10, "R4 mode written via ch1");
    // R5 R6 flags and merge
    set_irq(2'b01);
    chk_irq(0, "R6 ch0 masked");
    rd(4'h1, 8'h14, "R5 flag0");
    set_irq(2'b11);
    chk_irq(1, "R6 ch1 open");
    rd(4'h9, 8'h1C, "R5 both flags");
    wr(4'h1, 8'h20); chk_irq(1, "R6 ch0 open");
    wr(4'h1, 8'h30); chk_irq(0, "R6 both masked");
    wr(4'h1, 8'h00); chk_irq(1, "R6 unmasked");
    set_irq(2'b00);
    chk_irq(0, "R6 inputs low");
    rd(4'h1, 8'h00, "R5 flags follow level");
    // R8 R9 status
    rd(4'h2, 8'h04, "R8 evt0 latched");
    chan_active = 2'b01;
    rd(4'h2, 8'h05, "R9 active0"); rd(4'hA, 8'h04, "R9 active1 low");
    wr(4'h2, 8'hFF);
    rd(4'h2, 8'h61, "R7 ctl bits and R8 clear");
    rd(4'hA, 8'h04, "R8 other channel kept");
    @(posedge clk); #1 chan_err = 2'b10;
    @(posedge clk); #1 chan_err = 2'b00;
    rd(4'hA, 8'h06, "R8 err1 set");
    wr(4'hA, 8'h02); rd(4'hA, 8'h04, "R8 clear err only");
    wr(4'hA, 8'h04); rd(4'hA, 8'h00, "R8 clear evt");
    wr(4'h2, 8'h00); rd(4'h2, 8'h01, "R7 ctl cleared, R9 bit kept");
    // R6 same cycle: mask write meets rising input
    @(posedge clk); #1 io_addr = 4'h1; io_wdata = 8'h10; io_wr = 1; chan_irq = 2'b01;
    @(posedge clk); #1 io_wr = 0;
    chk_irq(0, "R6 same-cycle mask wins output");
    rd(4'h1, 8'h14, "R6 same-cycle both applied");
    wr(4'h1, 8'h00); chk_irq(1, "R6 unmask after collision");
    set_irq(2'b00);
    wr(4'h2, 8'h04); rd(4'h2, 8'h01, "R8 evt cleared");
    // R8 same cycle: clear meets new rise
    @(posedge clk); #1 io_addr = 4'h2; io_wdata = 8'h04; io_wr = 1; chan_irq = 2'b01;
    @(posedge clk); #1 io_wr = 0;
    rd(4'h2, 8'h05, "R8 set wins over clear");
    // R11 idle read data
    @(negedge clk);
    note(io_rdata === 8'h00, "R11 idle rdata", io_rdata, 8'h00);
    repeat (2) @(posedge clk);
    note(exp_q.size() == 0, "scoreboard drained", 8'(exp_q.size()), 8'h00);
    finish_run();
  end
endmodule